// File: doc/BRIEF.md
# Vertical Link Test-and-Repair Scan Chain

This block models, in digital form, the small cell that sits on every incoming vertical interconnect of a stacked die, and strings `N` of those cells into one scan chain. Each cell owns a single sampling flip-flop that does three jobs. It captures the link's pass/fail comparator result during link test. It shifts serial data during scan. It supplies the value that is copied into a per-link repair latch. The analog comparator and level conversion are outside the block and appear as one comparator-result bit per link, which also serves as the recovered signal.

Two shared controls pick the cell mode. `test_en` requests link test. `cap_sel` points the flip-flop input at the comparator rather than the scan input. With `test_en` low and `cap_sel` high the cell is in recovery (operating) mode: its sampling clock is treated as held high, so the flip-flop does not change and the repair latch is locked. A third shared control, `scan_mode`, sends each flip-flop to the downstream logic input for logic test. When `scan_mode` is low, each link's own repair latch chooses between the recovered comparator signal (repairable) and the raw link (good).

Top module: `link_repair_chain`

## Requirements
- R1: While `rst_n` is low and after its release, every flip-flop and every repair latch reads 0, `scan_out` is 0, and with `scan_mode` low every `logic_in[i]` follows `link_raw[i]`.
- R2: When `cap_sel` is 0 (shift mode), each rising clock loads cell 0 from `scan_in` and cell i from cell i-1. `scan_out` always shows cell N-1.
- R3: When `test_en` is 1 and `cap_sel` is 1 (capture mode), each rising clock loads cell i from `cmp_res[i]`.
- R4: When `test_en` is 0 and `cap_sel` is 1 (recovery mode), the flip-flops keep their values on every clock.
- R5: When `scan_mode` is 1, `logic_in[i]` equals the flip-flop of cell i.
- R6: When `scan_mode` is 0, `logic_in[i]` equals `cmp_res[i]` if the repair latch of cell i holds 1 (repairable), and equals `link_raw[i]` if it holds 0 (good).
- R7: Outside recovery mode, a clock edge with `cfg_load` high copies each cell's flip-flop into its repair latch.
- R8: In recovery mode, `cfg_load` has no effect and the repair latches keep their values.
- R9: With `cfg_load` low, the repair latches keep their values in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low reset of flip-flops and repair latches |
| test_en | input | 1 | Shared link-test request |
| cap_sel | input | 1 | Flip-flop input select: 1 comparator, 0 scan chain |
| scan_mode | input | 1 | Shared output select: 1 flip-flop, 0 per-link repair choice |
| cfg_load | input | 1 | Strobe that copies flip-flops into repair latches |
| scan_in | input | 1 | Serial input to cell 0 |
| cmp_res | input | N | Per-link comparator result, also the recovered signal |
| link_raw | input | N | Per-link raw signal |
| logic_in | output | N | Per-link drive to downstream logic |
| scan_out | output | 1 | Serial output from cell N-1 |

## Verification
The bench builds the chain with `N = 4`. At that size, all 16 comparator patterns can be captured, all 16 repair configurations can be loaded, and for each configuration all 256 combinations of comparator and raw inputs can be applied to the output selector. Four-bit serial patterns then reach the far end of the chain in a few clocks. This makes the shift order and the recovery-mode lock on both storage elements cheap to check exhaustively.

// File: rtl/link_repair_pkg.sv
package link_repair_pkg;

    typedef enum logic [1:0] {
        CELL_RECOVER = 2'd0,
        CELL_SHIFT   = 2'd1,
        CELL_CAPTURE = 2'd2
    } cell_mode_e;

    typedef struct packed {
        logic ff;
        logic rep;
    } cell_state_t;

endpackage

// File: rtl/link_mode_decode.sv
module link_mode_decode
    import link_repair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic cap_sel,
    output logic ff_en,
    output logic pick_link,
    output logic cfg_ok
);

    cell_mode_e mode;

    always_comb begin
        if (!cap_sel)
            mode = CELL_SHIFT;
        else if (test_en)
            mode = CELL_CAPTURE;
        else
            mode = CELL_RECOVER;
    end

    always_comb begin
        ff_en     = (mode != CELL_RECOVER);
        pick_link = (mode == CELL_CAPTURE);
        cfg_ok    = (mode != CELL_RECOVER);
    end

    // R4 / R8: recovery mode freezes both storage elements
    a_r4_recover_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en == 1'b0 && cap_sel == 1'b1) |-> (!ff_en && !cfg_ok));

    // R3: capture mode always takes the comparator path
    a_r3_capture_path: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && cap_sel) |-> (ff_en && pick_link));

endmodule

// File: rtl/link_cell.sv
module link_cell
    import link_repair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ff_en,
    input  logic pick_link,
    input  logic cfg_ok,
    input  logic cfg_load,
    input  logic scan_mode,
    input  logic ser_in,
    input  logic cmp_bit,
    input  logic raw_bit,
    output logic ff_out,
    output logic drive_out
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ff_en)
            st_d.ff = pick_link ? cmp_bit : ser_in;
        if (cfg_ok && cfg_load)
            st_d.rep = st_q.ff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        if (scan_mode)
            drive_out = st_q.ff;
        else if (st_q.rep)
            drive_out = cmp_bit;
        else
            drive_out = raw_bit;
    end

    assign ff_out = st_q.ff;

    // R3: captured bit is the comparator value of the previous cycle
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_en && pick_link) |=> (ff_out == $past(cmp_bit)));

    // R2: shift takes the serial input
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_en && !pick_link) |=> (ff_out == $past(ser_in)));

    // R4: flip-flop frozen when its clock is held
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ff_en) |=> $stable(ff_out));

    // R8 / R9: repair state only moves on an allowed strobe
    a_r8_latch_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ok && cfg_load) |=> $stable(st_q.rep));

    // R7: allowed strobe copies the flip-flop
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && cfg_load) |=> (st_q.rep == $past(ff_out)));

endmodule

// File: rtl/link_repair_chain.sv
module link_repair_chain
    import link_repair_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic         cap_sel,
    input  logic         scan_mode,
    input  logic         cfg_load,
    input  logic         scan_in,
    input  logic [N-1:0] cmp_res,
    input  logic [N-1:0] link_raw,
    output logic [N-1:0] logic_in,
    output logic         scan_out
);

    localparam int LAST = N - 1;

    logic         ff_en;
    logic         pick_link;
    logic         cfg_ok;
    logic [N-1:0] ff_vec;
    logic [N-1:0] ser_vec;

    link_mode_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (test_en),
        .cap_sel   (cap_sel),
        .ff_en     (ff_en),
        .pick_link (pick_link),
        .cfg_ok    (cfg_ok)
    );

    assign ser_vec[0] = scan_in;

    generate
        for (genvar i = 1; i < N; i++) begin : g_link
            assign ser_vec[i] = ff_vec[i-1];
        end
        for (genvar i = 0; i < N; i++) begin : g_cell
            link_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .ff_en     (ff_en),
                .pick_link (pick_link),
                .cfg_ok    (cfg_ok),
                .cfg_load  (cfg_load),
                .scan_mode (scan_mode),
                .ser_in    (ser_vec[i]),
                .cmp_bit   (cmp_res[i]),
                .raw_bit   (link_raw[i]),
                .ff_out    (ff_vec[i]),
                .drive_out (logic_in[i])
            );
        end
    endgenerate

    assign scan_out = ff_vec[LAST];

    // R2: chain end moves with the shift register
    a_r2_chain_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_sel) |=> (scan_out == $past(ff_vec[LAST-1 < 0 ? 0 : LAST-1])) || (N == 1));

endmodule

// File: tb/sim_link_repair_chain.sv
module sim_link_repair_chain;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_en = 1'b0;
    logic         cap_sel = 1'b0;
    logic         scan_mode = 1'b0;
    logic         cfg_load = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] cmp_res = '0;
    logic [N-1:0] link_raw = '0;
    logic [N-1:0] logic_in;
    logic         scan_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    link_repair_chain #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .cap_sel(cap_sel),
        .scan_mode(scan_mode), .cfg_load(cfg_load), .scan_in(scan_in),
        .cmp_res(cmp_res), .link_raw(link_raw), .logic_in(logic_in),
        .scan_out(scan_out)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // read flip-flops through the output selector (R5)
    task automatic read_ff(output logic [N-1:0] v);
        scan_mode = 1'b1;
        #1 v = logic_in;
        scan_mode = 1'b0;
        #1;
    endtask

    task automatic capture(input logic [N-1:0] p);
        test_en = 1'b1; cap_sel = 1'b1; cmp_res = p;
        step();
        test_en = 1'b0; cap_sel = 1'b0;
    endtask

    task automatic load_cfg(input logic [N-1:0] p);
        capture(p);
        cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
    endtask

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] expv;
        repeat (3) @(negedge clk);
        // R1: reset state
        link_raw = 4'b1010; cmp_res = 4'b0101; #1;
        check("R1 out follows raw in reset", logic_in, 4'b1010);
        check("R1 scan_out in reset", {3'b0, scan_out}, '0);
        rst_n = 1'b1;
        step();
        cap_sel = 1'b1;
        read_ff(v);
        check("R1 flops cleared", v, '0);
        #1 check("R1 latch cleared -> raw", logic_in, 4'b1010);
        cap_sel = 1'b0;

        // R3 / R5: every capture pattern
        for (int p = 0; p < 16; p++) begin
            capture(p[N-1:0]);
            cap_sel = 1'b1;
            read_ff(v);
            check("R3 capture", v, p[N-1:0]);
            check("R2 scan_out shows last cell", {3'b0, scan_out}, {3'b0, p[3]});
            cap_sel = 1'b0;
        end

        // R7 / R6: every repair configuration, every input combination
        for (int c = 0; c < 16; c++) begin
            load_cfg(c[N-1:0]);
            test_en = 1'b0; cap_sel = 1'b1;
            for (int k = 0; k < 256; k++) begin
                cmp_res = k[3:0]; link_raw = k[7:4];
                #1;
                expv = (c[N-1:0] & k[3:0]) | (~c[N-1:0] & k[7:4]);
                check("R6/R7 repair select", logic_in, expv);
            end
            cap_sel = 1'b0;
        end

        // R2: serial shift of every 4-bit pattern
        for (int s = 0; s < 16; s++) begin
            cap_sel = 1'b0; test_en = 1'b0;
            for (int b = 0; b < N; b++) begin
                scan_in = s[b];
                step();
            end
            cap_sel = 1'b1;
            read_ff(v);
            for (int i = 0; i < N; i++) expv[i] = s[N-1-i];
            check("R2 shift order", v, expv);
            check("R2 scan_out", {3'b0, scan_out}, {3'b0, s[0]});
            cap_sel = 1'b0;
        end

        // R4 / R8: recovery mode freezes flops and repair latch
        load_cfg(4'b0110);
        capture(4'b1001);
        test_en = 1'b0; cap_sel = 1'b1;
        cmp_res = 4'b0110; scan_in = 1'b1; cfg_load = 1'b1;
        repeat (3) step();
        cfg_load = 1'b0;
        read_ff(v);
        check("R4 flops held in recovery", v, 4'b1001);
        cmp_res = 4'b1100; link_raw = 4'b0011; #1;
        check("R8 latch unchanged in recovery", logic_in, 4'b0101);

        // R9: shifting without strobe leaves repair state
        cap_sel = 1'b0; scan_in = 1'b0;
        repeat (N) step();
        cap_sel = 1'b1;
        cmp_res = 4'b1111; link_raw = 4'b0000; #1;
        check("R9 latch held without strobe", logic_in, 4'b0110);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule